// File: doc/BRIEF.md
# Status Interrupt Generator with Debounce

This block gathers status events from a USB charger-detection engine and turns them into one interrupt line. The raw bus-voltage comparator is filtered so that a change is accepted only after it has held for a number of millisecond ticks. A change of the accepted level in either direction raises a cause. A change in the charger-type code raises a cause. A rising edge of the data-contact timeout flag also raises a cause.

Each cause stays latched until the status register that holds the causes is read. The read strobe clears every pending cause. An event that arrives in the same cycle as the read is kept pending. An enable input hides the pin without discarding causes. A polarity input selects the level that the pin drives.

The pin is modelled as an open-drain style pad. `irq_oe` enables the driver, and `irq_lvl` gives the level it drives. When the driver is not enabled, the pad floats to high impedance. Every port is a plain control or status pin, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_status_gen`

## Requirements
- R1: Any change of `vbus_ok`, in either direction, sets cause bit 0 of `cause_pend` on the next clock edge.
- R2: A 0-to-1 transition of `dcd_timeout` sets cause bit 2. A 1-to-0 transition, or a level held high, sets nothing.
- R3: `vbus_ok` takes the value of `vbus_raw` only after `vbus_raw` has differed from it on 30 consecutive `tick_1ms` pulses. If `vbus_raw` returns to the accepted value in any cycle, the count restarts from zero.
- R4: Any change of the `chg_type` code, from any value to any other value, sets cause bit 1.
- R5: Pending causes clear only in a cycle where `status_rd` is high, and that read clears all cause bits at once.
- R6: With `irq_en` at 0, `irq_oe` is 0 and pending causes stay latched. The causes appear on the pin again when `irq_en` returns to 1.
- R7: `irq_oe` is 1 exactly when `irq_en` is 1 and at least one cause is pending. `irq_lvl` equals `irq_pol`, so 0 means active-low and 1 means active-high.
- R8: An event that arrives in the same cycle as `status_rd` remains pending after the read.
- R9: Activity on `det_busy` never sets any cause bit.
- R10: After reset, `vbus_ok`, `cause_pend` and `irq_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| vbus_raw | input | 1 | Unfiltered bus-voltage comparator |
| chg_type | input | TYPE_W | Charger-type result code |
| dcd_timeout | input | 1 | Data-contact detection timeout flag |
| det_busy | input | 1 | Detection-running flag (never a cause) |
| status_rd | input | 1 | Strobe: cause register is being read |
| irq_en | input | 1 | Global interrupt enable |
| irq_pol | input | 1 | Pin polarity, 1 = active-high |
| vbus_ok | output | 1 | Debounced comparator level |
| cause_pend | output | 3 | Pending causes: bit0 bus, bit1 type, bit2 timeout |
| irq_oe | output | 1 | Pin driver enable |
| irq_lvl | output | 1 | Level driven while enabled |

## Verification
The bench checks a read that coincides with new events. A latch that lets the clear win would lose those events. It checks reads taken while the pin is masked, and toggling of the enable. A design that cleared causes on masking would fail to bring the pin back. On the filter, the bench interrupts a run of ticks with one cycle back at the old level, then stops one tick short of the hold time. A counter that does not restart, or that is off by one, would accept too early. The bench also confirms three things: the timeout flag falling edge and a held-high level do nothing, a removal raises the same cause as an insertion, and the running flag is ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_CAUSE  = 3;
  localparam int unsigned IDX_VBUS = 0;
  localparam int unsigned IDX_TYPE = 1;
  localparam int unsigned IDX_DCD  = 2;
  typedef logic [N_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/irq_debounce.sv
module irq_debounce #(
  parameter int unsigned HOLD_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (raw == stable_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        stable_q <= raw;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level = stable_q;

  // R3
  deb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_q != $past(stable_q)) |-> ($past(tick) && ($past(raw) == stable_q)));

  // R3
  deb_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HOLD_TICKS));
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect
  import irq_pkg::*;
#(
  parameter int unsigned TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_lvl,
  input  logic [TYPE_W-1:0] chg_type,
  input  logic              dcd_to,
  output cause_vec_t        ev
);
  logic              vbus_prev;
  logic [TYPE_W-1:0] type_prev;
  logic              dcd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_prev <= 1'b0;
      type_prev <= '0;
      dcd_prev  <= 1'b0;
    end else begin
      vbus_prev <= vbus_lvl;
      type_prev <= chg_type;
      dcd_prev  <= dcd_to;
    end
  end

  always_comb begin
    ev           = '0;
    ev[IDX_VBUS] = vbus_lvl ^ vbus_prev;
    ev[IDX_TYPE] = (chg_type != type_prev);
    ev[IDX_DCD]  = dcd_to & ~dcd_prev;
  end
endmodule

// File: rtl/irq_cause_latch.sv
module irq_cause_latch
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t ev,
  input  logic       clr,
  output cause_vec_t pend
);
  cause_vec_t pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (clr ? '0 : pend_q) | ev;
  end

  assign pend = pend_q;

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_chk
    // R8
    ev_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> pend_q[i]);
    // R5
    clr_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_q[i]) && !pend_q[i]) |-> $past(clr));
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic en,
  input  logic pol,
  input  logic any_pend,
  output logic oe,
  output logic lvl
);
  assign oe  = en & any_pend;
  assign lvl = pol;
endmodule

// File: rtl/irq_status_gen.sv
module irq_status_gen
  import irq_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 30,
  parameter int unsigned TYPE_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1ms,
  input  logic                vbus_raw,
  input  logic [TYPE_W-1:0]   chg_type,
  input  logic                dcd_timeout,
  input  logic                det_busy,
  input  logic                status_rd,
  input  logic                irq_en,
  input  logic                irq_pol,
  output logic                vbus_ok,
  output logic [N_CAUSE-1:0]  cause_pend,
  output logic                irq_oe,
  output logic                irq_lvl
);
  cause_vec_t ev;
  cause_vec_t pend;

  irq_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .raw(vbus_raw), .level(vbus_ok)
  );

  irq_event_detect #(.TYPE_W(TYPE_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .vbus_lvl(vbus_ok), .chg_type(chg_type),
    .dcd_to(dcd_timeout), .ev(ev)
  );

  irq_cause_latch u_lat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(status_rd), .pend(pend)
  );

  irq_pin_drv u_pin (
    .en(irq_en), .pol(irq_pol), .any_pend(|pend), .oe(irq_oe), .lvl(irq_lvl)
  );

  assign cause_pend = pend;

  // R1
  vbus_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_ok != $past(vbus_ok)) |=> pend[IDX_VBUS]);

  // R2
  dcd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_timeout && !$past(dcd_timeout)) |=> pend[IDX_DCD]);

  // R6
  mask_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !status_rd && (|pend)) |=> (|pend));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_busy != $past(det_busy)) && (vbus_ok == $past(vbus_ok)) &&
     (chg_type == $past(chg_type)) && !(dcd_timeout && !$past(dcd_timeout)) &&
     !status_rd) |=> (pend == $past(pend)));
endmodule

// File: tb/irq_status_gen_test.sv
module irq_status_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, vbus_raw = 1'b0, dcd_to = 1'b0, det_busy = 1'b0;
  logic       rd = 1'b0, en = 1'b0, pol = 1'b0;
  logic [2:0] chg_type = 3'd0;
  logic       vbus_ok, oe, lvl;
  logic [2:0] pend;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_status_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .vbus_raw(vbus_raw),
    .chg_type(chg_type), .dcd_timeout(dcd_to), .det_busy(det_busy),
    .status_rd(rd), .irq_en(en), .irq_pol(pol), .vbus_ok(vbus_ok),
    .cause_pend(pend), .irq_oe(oe), .irq_lvl(lvl)
  );

  // {type[2:0], dcd, rd, en, pol, exp_pend[2:0], exp_oe}
  localparam logic [10:0] VEC [0:12] = '{
    11'b000_0_0_1_0_000_0,
    11'b001_0_0_1_0_010_1,
    11'b001_0_0_0_0_010_0,
    11'b001_0_0_1_1_010_1,
    11'b001_0_1_1_1_000_0,
    11'b001_1_0_1_1_100_1,
    11'b001_1_1_1_1_000_0,
    11'b001_0_0_1_1_000_0,
    11'b011_1_1_1_1_110_1,
    11'b011_1_0_0_1_110_0,
    11'b011_0_1_0_1_000_0,
    11'b000_0_0_1_0_010_1,
    11'b000_0_1_1_0_000_0
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 vbus_ok", vbus_ok, 0);
    check("R10 pend", pend, 0);
    check("R10 oe", oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pend after release", pend, 0);

    // vector table: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < 13; i++) begin
      {chg_type, dcd_to, rd, en, pol} = VEC[i][10:4];
      @(posedge clk);
      #1;
      check($sformatf("R2/R4/R5/R6/R8 pend vec %0d", i), pend, VEC[i][3:1]);
      check($sformatf("R6/R7 oe vec %0d", i), oe, VEC[i][0]);
      check($sformatf("R7 lvl vec %0d", i), lvl, pol);
      @(negedge clk);
    end
    rd = 1'b0;
    en = 1'b1;

    // R9: busy flag activity alone
    for (int k = 0; k < 6; k++) begin
      det_busy = ~det_busy;
      @(negedge clk);
    end
    check("R9 pend", pend, 0);
    check("R9 oe", oe, 0);

    // R3: interrupted run restarts the count
    vbus_raw = 1'b1;
    pulse_tick(10);
    vbus_raw = 1'b0;
    @(negedge clk);
    vbus_raw = 1'b1;
    pulse_tick(29);
    check("R3 not yet accepted", vbus_ok, 0);
    check("R3 no cause early", pend, 0);
    pulse_tick(1);
    check("R3 accepted at 30", vbus_ok, 1);
    @(posedge clk);
    #1;
    check("R1 rise cause", pend, 3'b001);
    check("R1 rise oe", oe, 1);
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R5 cleared", pend, 0);

    // R1: removal also raises
    vbus_raw = 1'b0;
    pulse_tick(29);
    check("R3 removal not yet", vbus_ok, 1);
    pulse_tick(1);
    check("R3 removal accepted", vbus_ok, 0);
    @(posedge clk);
    #1;
    check("R1 fall cause", pend, 3'b001);
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule